// File: doc/BRIEF.md
# Scaling-Free Pipelined Sine/Cosine Rotator

This block turns a phase angle into its cosine and sine. It accepts one new angle on every clock. It is fully pipelined, with one shift-and-add micro-rotation per stage. The angle covers a full turn as an unsigned 16-bit fraction. The results are signed fixed-point words with 14 fractional bits. The design needs no scale-factor correction and no sign decision at any stage.

Each stage applies a third-order Taylor approximation of a rotation by 2^-i radians, for i = 2 to 15. A stage either applies that rotation or passes its vector through unchanged, and one bit of the reduced angle makes the choice. The rotation always turns the same way.

Before the stages, the input side folds the angle into the first 45-degree sector. It converts the residual to radians with a shift-add multiply by pi. A residual of pi/8 or more is handled by starting from the constant vector (cos pi/8, sin pi/8), so the rotators only cover the range below pi/8. The 3-bit sector code travels beside the data. At the output it selects a swap and a negation of the result, so both values have the correct sign in every quadrant.

Top module: `sfcordic_rot`

## Requirements
- R1: Reset is synchronous and active high. In the cycle after any clock edge that samples `rst` high, `out_vld` is 0.
- R2: An angle sampled with `ang_vld` high in cycle n produces `out_vld` high in cycle n+16. Angles may arrive on back-to-back cycles, and each one yields exactly one result.
- R3: `ang` is an unsigned 16-bit fraction of a full turn: the value a stands for 2*pi*a/65536 radians. `out_cos` is signed two's complement with 14 fractional bits (16384 means 1.0). It stays within 12 LSB of round(16384*cos).
- R4: `out_sin` uses the same format and stays within 12 LSB of round(16384*sin) of the same angle.
- R5: On the four axis angles the outputs are exact: 0 gives (16384, 0), 16384 gives (0, 16384), 32768 gives (-16384, 0) and 49152 gives (0, -16384).
- R6: A cycle with `ang_vld` low yields `out_vld` low 16 cycles later, so the valid pattern comes out unchanged whatever `ang` held in the idle cycles.
- R7: A reset clears every result in flight. For 16 cycles after reset is released, `out_vld` stays 0 whatever was in the pipeline beforehand.
- R8: Both edges of each of the eight 45-degree sectors (a = k*8192 and a = k*8192 + 8191) meet the tolerances of R3 and R4. Here the sector code is `ang[15:13]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ang_vld | input | 1 | Angle on `ang` is valid this cycle |
| ang | input | 16 | Angle as an unsigned fraction of a full turn |
| out_vld | output | 1 | Result pair is valid this cycle |
| out_cos | output | 16 | Cosine, signed, 14 fractional bits |
| out_sin | output | 16 | Sine, signed, 14 fractional bits |

## Verification
A synchronous flush and the acceptance of a new angle can fall in the same cycle. The bench streams angles back to back and raises `rst` in a cycle where `ang_vld` is also high. It then requires `out_vld` to stay low through the next full pipeline depth, and requires angles given after release to come out with correct values and timing. The accuracy of every one of the 65536 angles is judged against a real-valued cosine and sine computed in the bench. The sector edges and the exact axis values are judged separately.

// File: rtl/sfcordic_pkg.sv
package sfcordic_pkg;
    localparam int ANG_W   = 16;              // angle word, fraction of a turn
    localparam int OCT_W   = 3;               // sector code width
    localparam int RES_W   = ANG_W - OCT_W;   // residual inside a sector
    localparam int OUT_W   = 16;              // result word
    localparam int GUARD   = 2;               // internal guard bits
    localparam int INT_W   = OUT_W + GUARD;   // internal vector width
    localparam int FRAC_I  = INT_W - 2;       // fractional bits inside
    localparam int I_FIRST = 2;               // first micro-rotation index
    localparam int Z_W     = ANG_W - I_FIRST; // angle bits driving stages
    localparam int N_STG   = Z_W;             // one stage per angle bit
    localparam int LAT     = N_STG + 2;       // prep + stages + output map
    localparam int MUL_FR  = 10;              // fraction bits of pi product
    localparam int PROD_W  = RES_W + 1 + 12;  // fold * (pi * 2^MUL_FR)
    localparam int ZF_W    = PROD_W - MUL_FR;

    // pi/8 in units of 2^-(I_FIRST+Z_W-1) rad, and the pi/8 start vector in Q1.FRAC_I
    localparam int PI8_Z   = 12868;
    localparam int COS8_Q  = 60547;
    localparam int SIN8_Q  = 25080;

    typedef struct packed {
        logic                    vld;
        logic [OCT_W-1:0]        oct;
        logic [Z_W-1:0]          z;
        logic signed [INT_W-1:0] x;
        logic signed [INT_W-1:0] y;
    } rot_t;

    typedef struct packed {
        logic                    vld;
        logic signed [OUT_W-1:0] c;
        logic signed [OUT_W-1:0] s;
    } res_t;
endpackage

// File: rtl/sfcordic_prep.sv
module sfcordic_prep
    import sfcordic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             vld_i,
    input  logic [ANG_W-1:0] ang_i,
    output rot_t             st_o
);
    localparam logic [RES_W:0]          SECTOR = (RES_W+1)'(1 << RES_W);
    localparam logic [ZF_W-1:0]         PI8    = ZF_W'(PI8_Z);
    localparam logic signed [INT_W-1:0] X_ONE  = INT_W'(1 << FRAC_I);
    localparam logic signed [INT_W-1:0] X_C8   = INT_W'(COS8_Q);
    localparam logic signed [INT_W-1:0] Y_S8   = INT_W'(SIN8_Q);
    localparam logic [PROD_W-1:0]       RHALF  = PROD_W'(1 << (MUL_FR - 1));

    rot_t              st_d, st_q;
    logic [RES_W:0]    fold;
    logic [PROD_W-1:0] fw, prod;
    logic [ZF_W-1:0]   zf;

    always_comb begin
        st_d     = '0;
        st_d.vld = vld_i;
        st_d.oct = ang_i[ANG_W-1 -: OCT_W];
        // odd sectors measure from the far edge
        if (st_d.oct[0]) fold = SECTOR - {1'b0, ang_i[RES_W-1:0]};
        else             fold = {1'b0, ang_i[RES_W-1:0]};
        // radians = fold * pi * 2^-15 ; pi*1024 ~ 2048+1024+128+16+1
        fw   = PROD_W'(fold);
        prod = (fw << 11) + (fw << 10) + (fw << 7) + (fw << 4) + fw + RHALF;
        zf   = prod[PROD_W-1:MUL_FR];
        if (zf >= PI8) begin
            st_d.z = Z_W'(zf - PI8);
            st_d.x = X_C8;
            st_d.y = Y_S8;
        end else begin
            st_d.z = Z_W'(zf);
            st_d.x = X_ONE;
            st_d.y = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign st_o = st_q;
endmodule

// File: rtl/sfcordic_stage.sv
module sfcordic_stage
    import sfcordic_pkg::*;
#(
    parameter int IDX = I_FIRST
) (
    input  logic clk,
    input  logic rst,
    input  rot_t st_i,
    output rot_t st_o
);
    localparam int SH1 = IDX;
    localparam int SH2 = 2 * IDX + 1;
    localparam int SH3 = 3 * IDX;
    localparam int ZB  = Z_W - 1 + I_FIRST - IDX;

    rot_t st_d, st_q;
    logic signed [INT_W-1:0] nx, ny;

    // v/6 ~ v*(1/8+1/32+1/128+1/512+1/2048)
    function automatic logic signed [INT_W-1:0] div6(input logic signed [INT_W-1:0] v);
        return (v >>> 3) + (v >>> 5) + (v >>> 7) + (v >>> 9) + (v >>> 11);
    endfunction

    always_comb begin
        nx   = st_i.x - (st_i.x >>> SH2) - (st_i.y >>> SH1) + div6(st_i.y >>> SH3);
        ny   = st_i.y - (st_i.y >>> SH2) + (st_i.x >>> SH1) - div6(st_i.x >>> SH3);
        st_d = st_i;
        if (st_i.z[ZB]) begin
            st_d.x = nx;
            st_d.y = ny;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign st_o = st_q;
endmodule

// File: rtl/sfcordic_post.sv
module sfcordic_post
    import sfcordic_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  rot_t st_i,
    output res_t res_o
);
    localparam logic signed [INT_W-1:0] RND = INT_W'(1 << (GUARD - 1));

    res_t res_d, res_q;
    logic signed [INT_W-1:0] xr, yr;
    logic signed [OUT_W-1:0] cu, su, cp, sp;

    always_comb begin
        xr = (st_i.x + RND) >>> GUARD;
        yr = (st_i.y + RND) >>> GUARD;
        cu = OUT_W'(xr);
        su = OUT_W'(yr);
        // upper half of a quadrant: cos and sin trade places
        if (st_i.oct[0]) begin
            cp = su;
            sp = cu;
        end else begin
            cp = cu;
            sp = su;
        end
        res_d     = '0;
        res_d.vld = st_i.vld;
        case (st_i.oct[OCT_W-1 -: 2])
            2'd0:    begin res_d.c = cp;  res_d.s = sp;  end
            2'd1:    begin res_d.c = -sp; res_d.s = cp;  end
            2'd2:    begin res_d.c = -cp; res_d.s = -sp; end
            default: begin res_d.c = sp;  res_d.s = -cp; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign res_o = res_q;
endmodule

// File: rtl/sfcordic_rot.sv
module sfcordic_rot
    import sfcordic_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ang_vld,
    input  logic [ANG_W-1:0]        ang,
    output logic                    out_vld,
    output logic signed [OUT_W-1:0] out_cos,
    output logic signed [OUT_W-1:0] out_sin
);
    rot_t chain [N_STG+1];
    res_t res;

    sfcordic_prep i_prep (
        .clk   (clk),
        .rst   (rst),
        .vld_i (ang_vld),
        .ang_i (ang),
        .st_o  (chain[0])
    );

    for (genvar g = 0; g < N_STG; g++) begin : g_stage
        sfcordic_stage #(.IDX(I_FIRST + g)) i_stage (
            .clk  (clk),
            .rst  (rst),
            .st_i (chain[g]),
            .st_o (chain[g+1])
        );
    end

    sfcordic_post i_post (
        .clk   (clk),
        .rst   (rst),
        .st_i  (chain[N_STG]),
        .res_o (res)
    );

    assign out_vld = res.vld;
    assign out_cos = res.c;
    assign out_sin = res.s;
endmodule

// File: rtl/sfcordic_rot_chk.sv
module sfcordic_rot_chk
    import sfcordic_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    ang_vld,
    input logic [ANG_W-1:0]        ang,
    input logic                    out_vld,
    input logic signed [OUT_W-1:0] out_cos,
    input logic signed [OUT_W-1:0] out_sin
);
    localparam logic signed [OUT_W-1:0] Q_ONE = OUT_W'(1 << (OUT_W - 2));

    logic [LAT-1:0]           hv;
    logic [ANG_W-1:0]         ha [LAT];
    logic [$clog2(LAT+1)-1:0] since_rst;
    logic [ANG_W-1:0]         a_old;
    logic                     on_axis, axis_ok;

    always_ff @(posedge clk) begin
        if (rst) hv <= '0;
        else     hv <= {hv[LAT-2:0], ang_vld};
        ha[0] <= ang;
        for (int k = 1; k < LAT; k++) ha[k] <= ha[k-1];
        if (rst)                   since_rst <= '0;
        else if (since_rst < LAT)  since_rst <= since_rst + 1'b1;
    end

    always_comb begin
        a_old   = ha[LAT-1];
        on_axis = (a_old[ANG_W-3:0] == '0);
        case (a_old[ANG_W-1 -: 2])
            2'd0:    axis_ok = (out_cos == Q_ONE)  && (out_sin == '0);
            2'd1:    axis_ok = (out_cos == '0)     && (out_sin == Q_ONE);
            2'd2:    axis_ok = (out_cos == -Q_ONE) && (out_sin == '0);
            default: axis_ok = (out_cos == '0)     && (out_sin == -Q_ONE);
        endcase
    end

    // R1: reset leaves no valid result behind
    p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !out_vld);

    // R2: valid appears exactly the pipeline depth after acceptance
    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        hv[LAT-1] |-> out_vld);

    // R6: an idle input cycle never produces a result
    p_no_phantom_r6: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> hv[LAT-1]);

    // R5: axis angles give exact results
    p_axis_exact_r5: assert property (@(posedge clk) disable iff (rst)
        (out_vld && on_axis) |-> axis_ok);

    // R7: nothing emerges until a full depth has passed since reset
    p_flush_r7: assert property (@(posedge clk) disable iff (rst)
        (since_rst < LAT) |-> !out_vld);
endmodule

bind sfcordic_rot sfcordic_rot_chk i_chk (.*);

// File: tb/test_sfcordic_rot.sv
module test_sfcordic_rot;
    import sfcordic_pkg::*;

    localparam int CLK_NS = 10;
    localparam int RING   = 32;
    localparam int TOL    = 12;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    ang_vld = 1'b0;
    logic [ANG_W-1:0]        ang = '0;
    logic                    out_vld;
    logic signed [OUT_W-1:0] out_cos, out_sin;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    string vtag = "R1";

    logic             ring_v [RING];
    logic [ANG_W-1:0] ring_a [RING];

    sfcordic_rot i_sfcordic_rot (
        .clk     (clk),
        .rst     (rst),
        .ang_vld (ang_vld),
        .ang     (ang),
        .out_vld (out_vld),
        .out_cos (out_cos),
        .out_sin (out_sin)
    );

    always #(CLK_NS / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    // record what the design samples at each edge
    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < RING; k++) ring_v[k] <= 1'b0;
        end else begin
            ring_v[cyc % RING] <= ang_vld;
        end
        ring_a[cyc % RING] <= ang;
        cyc <= cyc + 1;
    end

    // output monitor, away from the active edge
    always @(negedge clk) begin : mon
        int  idx;
        bit  ev;
        int  a, ec, es, dc, ds;
        real th;
        if (cyc > 0 && !done) begin
            ev = 1'b0;
            a  = 0;
            if (cyc >= LAT) begin
                idx = (cyc - LAT) % RING;
                ev  = ring_v[idx];
                a   = int'(ring_a[idx]);
            end
            // R1 / R2 / R6 / R7 depending on phase
            chk(out_vld == ev, vtag, int'(out_vld), int'(ev));
            if (ev && out_vld) begin
                th = 2.0 * 3.14159265358979 * real'(a) / 65536.0;
                ec = int'(16384.0 * $cos(th));
                es = int'(16384.0 * $sin(th));
                dc = int'(out_cos) - ec;
                ds = int'(out_sin) - es;
                chk(dc <= TOL && dc >= -TOL, "R3", int'(out_cos), ec);
                chk(ds <= TOL && ds >= -TOL, "R4", int'(out_sin), es);
                if ((a % 16384) == 0) begin
                    chk(int'(out_cos) == ec, "R5", int'(out_cos), ec);
                    chk(int'(out_sin) == es, "R5", int'(out_sin), es);
                end
                if ((a % 8192) == 0 || (a % 8192) == 8191) begin
                    chk(dc <= TOL && dc >= -TOL && ds <= TOL && ds >= -TOL,
                        "R8", int'(out_cos) * 65536 + int'(out_sin), ec * 65536 + es);
                end
            end
        end
    end

    task automatic drive(input bit v, input int a);
        @(negedge clk);
        ang_vld = v;
        ang     = ANG_W'(a);
    endtask

    initial begin
        repeat (3) drive(1'b1, 16'h1234);   // R1: valid input ignored under reset
        @(negedge clk);
        rst  = 1'b0;
        vtag = "R2";
        // R2, R3, R4, R5, R8: exhaustive back-to-back sweep
        for (int a = 0; a < 65536; a++) drive(1'b1, a);
        // R6: sparse valid pattern with junk in idle cycles
        vtag = "R6";
        for (int k = 0; k < 60; k++) begin
            if ((k % 3 == 0) || (k % 5 == 1)) drive(1'b1, (k * 2731) % 65536);
            else                              drive(1'b0, 16'hFFFF);
        end
        repeat (LAT + 2) drive(1'b0, 0);
        // R7: reset while angles are in flight and one is being accepted
        vtag = "R2";
        for (int k = 0; k < 10; k++) drive(1'b1, k * 4099);
        vtag = "R7";
        @(negedge clk);
        rst     = 1'b1;
        ang_vld = 1'b1;
        ang     = 16'h2000;
        @(negedge clk);
        rst     = 1'b0;
        ang_vld = 1'b0;
        repeat (LAT + 2) drive(1'b0, 0);
        // R8: both edges of every sector after the flush
        vtag = "R2";
        for (int k = 0; k < 8; k++) begin
            drive(1'b1, k * 8192);
            drive(1'b1, k * 8192 + 8191);
        end
        repeat (LAT + 4) drive(1'b0, 0);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        finish_run();
    end
endmodule